// File: doc/BRIEF.md
# Split-Access Load/Store Unit

This unit connects a processor-side request port to a byte-addressed memory. The memory port is 32 bits wide and takes only word-aligned addresses. The processor may ask for a byte, half-word or word load or store at any byte address. When an access is not naturally aligned, the unit breaks it into two aligned memory transactions. For loads it gathers the returned bytes back into one value and extends that value to 32 bits. A configuration input chooses how the bytes of a register value are placed in memory: least significant byte first, or most significant byte first. The register value itself carries no byte order.

Each request passes through a small state machine:

- ST_IDLE accepts a request (IDLE→FIRST on `req_valid`).
- ST_FIRST issues the lower-address transaction. On `mem_ready` it moves to ST_SECOND if the access is split (FIRST→SECOND), and to ST_RESP otherwise (FIRST→RESP).
- ST_SECOND issues the upper-address transaction and moves to ST_RESP on `mem_ready` (SECOND→RESP).
- ST_RESP raises the response for one cycle and always returns to ST_IDLE (RESP→IDLE).

A request therefore blocks the port until its last memory transaction has finished.

Top module: `lsu_unaligned`

## Requirements
- R1: While reset is asserted and after it is released with no request, `req_ready` is 1, `mem_valid` is 0 and `resp_valid` is 0.
- R2: `req_size` encodes 0 = byte, 1 = half-word, 2 or 3 = word. A byte at any address, a half-word at an even address and a word at an address that is a multiple of 4 each cause exactly one memory transaction. That transaction is raised in the cycle after acceptance.
- R3: A half-word at an odd address, or a word at an address that is not a multiple of 4, causes exactly two transactions. The access is split at the next address that is a multiple of its size. The lower-address part goes first.
- R4: `mem_addr` always has bits [1:0] equal to zero. Byte lane k (`mem_wdata`/`mem_rdata` bits [8k+7:8k], enable `mem_be[k]`) is byte address `mem_addr`+k. Only the lanes of the accessed bytes are enabled, so at least one is set.
- R5: With `cfg_big_endian` = 0, value byte i (bits [8i+7:8i]) is stored at the request address plus i.
- R6: With `cfg_big_endian` = 1, value byte i of an n-byte access is stored at the request address plus n-1-i. For example, word 06AB434Ch puts 06h at the lowest address.
- R7: A load returns, on `resp_rdata`, the value rebuilt from memory under the selected byte order. This holds for split and unsplit accesses alike.
- R8: For a byte or half-word load, the upper bits of `resp_rdata` are copies of the value's top bit when `req_signed` = 1 and zeros otherwise.
- R9: From acceptance until the response cycle has ended, `req_ready` is 0. A request held on the port meanwhile is neither accepted nor issued to memory.
- R10: While `mem_valid` is 1 and `mem_ready` is 0, `mem_addr`, `mem_be`, `mem_wdata` and `mem_write` hold their values into the next cycle.
- R11: `resp_valid` is high for exactly one cycle, the cycle after the handshake of the last memory transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_big_endian | input | 1 | Byte order, sampled at acceptance (1 = most significant byte at lowest address) |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Unit can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_signed | input | 1 | Sign-extend load result |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store value, right-justified |
| resp_valid | output | 1 | Request complete (one cycle) |
| resp_rdata | output | 32 | Load result |
| mem_valid | output | 1 | Memory transaction present |
| mem_ready | input | 1 | Memory takes the transaction; read data valid this cycle |
| mem_write | output | 1 | Transaction is a write |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data by lane |
| mem_rdata | input | 32 | Read data by lane |

## Verification
The bench targets the access shapes where the split point is easy to get wrong:

- A half-word at an odd offset inside one word has to split into two transactions to the same word. A design that splits only at word crossings would issue a single transaction.
- A half-word at offset 3 and a word at offset 1 cross into the next word. A wrong next-word address or wrong enables there would corrupt neighbouring bytes, which the bench detects by reading its memory back.

Byte order is checked by storing in one order and loading in the other. A reversal applied to the wrong span, such as the full word instead of the access size, shows up as a misplaced byte.

Sign extension is exercised with bytes and half-words whose top bit is set. A request is held on the port during a split store, to catch a design that takes it early. Memory stalls are inserted to catch transaction fields that change before the handshake.

// File: rtl/lsu_unaligned_pkg.sv
package lsu_unaligned_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND,
        ST_RESP
    } lsu_state_e;

    // Number of bytes covered by a size code; codes 2 and 3 are both a word.
    function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
        logic [2:0] n;
        unique case (code)
            2'd0:    n = 3'd1;
            2'd1:    n = 3'd2;
            default: n = 3'd4;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/lsu_lane_map.sv
// Maps each value byte of the current access to a transaction part and a lane.
module lsu_lane_map
    import lsu_unaligned_pkg::*;
(
    input  logic [1:0]                   off,
    input  logic [1:0]                   size,
    input  logic                         big,
    input  logic [DATA_W-1:0]            wdata,
    output logic                         split,
    output logic                         next_word,
    output logic [LANES-1:0]             be0,
    output logic [LANES-1:0]             be1,
    output logic [DATA_W-1:0]            wd0,
    output logic [DATA_W-1:0]            wd1,
    output logic [LANES-1:0]             byte_valid,
    output logic [LANES-1:0]             src_part,
    output logic [LANES-1:0][1:0]        src_lane
);

    logic [2:0] nbytes;
    logic [1:0] mask;
    logic [2:0] bnd;

    always_comb begin
        nbytes    = size_to_bytes(size);
        mask      = 2'(nbytes - 3'd1);
        // Split point: next address that is a multiple of the access size.
        bnd       = {1'b0, off & ~mask} + nbytes;
        split     = (off & mask) != 2'd0;
        next_word = bnd[2];
    end

    always_comb begin
        logic [2:0] j;
        logic [2:0] q;
        logic [1:0] ln;
        be0        = '0;
        be1        = '0;
        wd0        = '0;
        wd1        = '0;
        byte_valid = '0;
        src_part   = '0;
        src_lane   = '0;
        for (int v = 0; v < LANES; v++) begin
            j  = '0;
            q  = '0;
            ln = '0;
            if (3'(v) < nbytes) begin
                j  = big ? 3'(nbytes - 3'd1 - 3'(v)) : 3'(v);
                q  = {1'b0, off} + j;
                ln = q[1:0];
                byte_valid[v] = 1'b1;
                src_lane[v]   = ln;
                if (q >= bnd) begin
                    src_part[v]               = 1'b1;
                    be1[ln]                   = 1'b1;
                    wd1[{ln, 3'b000} +: LANE_W] = wdata[v*LANE_W +: LANE_W];
                end else begin
                    be0[ln]                   = 1'b1;
                    wd0[{ln, 3'b000} +: LANE_W] = wdata[v*LANE_W +: LANE_W];
                end
            end
        end
    end

endmodule

// File: rtl/lsu_load_merge.sv
// Gathers load bytes from one or two memory words and extends the result.
module lsu_load_merge
    import lsu_unaligned_pkg::*;
(
    input  logic [DATA_W-1:0]      word0,
    input  logic [DATA_W-1:0]      word1,
    input  logic [LANES-1:0]       byte_valid,
    input  logic [LANES-1:0]       src_part,
    input  logic [LANES-1:0][1:0]  src_lane,
    input  logic [1:0]             size,
    input  logic                   sext,
    output logic [DATA_W-1:0]      result
);

    logic [LANES-1:0][LANE_W-1:0] raw;
    logic                         top_bit;

    for (genvar g = 0; g < LANES; g++) begin : g_pick
        logic [LANE_W-1:0] from0;
        logic [LANE_W-1:0] from1;
        assign from0  = word0[{src_lane[g], 3'b000} +: LANE_W];
        assign from1  = word1[{src_lane[g], 3'b000} +: LANE_W];
        assign raw[g] = src_part[g] ? from1 : from0;
    end

    always_comb begin
        unique case (size)
            2'd0:    top_bit = raw[0][LANE_W-1];
            2'd1:    top_bit = raw[1][LANE_W-1];
            default: top_bit = 1'b0;
        endcase
        for (int b = 0; b < LANES; b++) begin
            result[b*LANE_W +: LANE_W] = byte_valid[b] ? raw[b]
                                                       : {LANE_W{sext & top_bit}};
        end
    end

endmodule

// File: rtl/lsu_unaligned.sv
module lsu_unaligned
    import lsu_unaligned_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_big_endian,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              resp_valid,
    output logic [31:0]       resp_rdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata
);

    localparam int WORD_W = ADDR_W - 2;

    lsu_state_e state, state_nx;

    logic              r_write;
    logic [1:0]        r_size;
    logic              r_signed;
    logic              r_big;
    logic [ADDR_W-1:0] r_addr;
    logic [DATA_W-1:0] r_wdata;
    logic [DATA_W-1:0] r_rd0;
    logic [DATA_W-1:0] r_resp;

    logic                  split, next_word;
    logic [LANES-1:0]      be0, be1, byte_valid, src_part;
    logic [DATA_W-1:0]     wd0, wd1, merged, merge_w0;
    logic [LANES-1:0][1:0] src_lane;
    logic [WORD_W-1:0]     word_lo, word_hi;
    logic                  accept, hs;

    lsu_lane_map u_map (
        .off        (r_addr[1:0]),
        .size       (r_size),
        .big        (r_big),
        .wdata      (r_wdata),
        .split      (split),
        .next_word  (next_word),
        .be0        (be0),
        .be1        (be1),
        .wd0        (wd0),
        .wd1        (wd1),
        .byte_valid (byte_valid),
        .src_part   (src_part),
        .src_lane   (src_lane)
    );

    assign merge_w0 = (state == ST_SECOND) ? r_rd0 : mem_rdata;

    lsu_load_merge u_merge (
        .word0      (merge_w0),
        .word1      (mem_rdata),
        .byte_valid (byte_valid),
        .src_part   (src_part),
        .src_lane   (src_lane),
        .size       (r_size),
        .sext       (r_signed),
        .result     (merged)
    );

    assign word_lo = r_addr[ADDR_W-1:2];
    assign word_hi = next_word ? word_lo + WORD_W'(1) : word_lo;
    assign accept  = req_valid && req_ready;
    assign hs      = mem_valid && mem_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = ST_FIRST;
            ST_FIRST:  if (mem_ready) state_nx = split ? ST_SECOND : ST_RESP;
            ST_SECOND: if (mem_ready) state_nx = ST_RESP;
            ST_RESP:   state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b0;
        mem_valid  = 1'b0;
        resp_valid = 1'b0;
        mem_write  = r_write;
        mem_addr   = {word_lo, 2'b00};
        mem_be     = be0;
        mem_wdata  = wd0;
        unique case (state)
            ST_IDLE:   req_ready = 1'b1;
            ST_FIRST:  mem_valid = 1'b1;
            ST_SECOND: begin
                mem_valid = 1'b1;
                mem_addr  = {word_hi, 2'b00};
                mem_be    = be1;
                mem_wdata = wd1;
            end
            ST_RESP:   resp_valid = 1'b1;
        endcase
    end

    // Request capture and load data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_write  <= 1'b0;
            r_size   <= 2'd0;
            r_signed <= 1'b0;
            r_big    <= 1'b0;
            r_addr   <= '0;
            r_wdata  <= '0;
            r_rd0    <= '0;
            r_resp   <= '0;
        end else begin
            if (accept) begin
                r_write  <= req_write;
                r_size   <= req_size;
                r_signed <= req_signed;
                r_big    <= cfg_big_endian;
                r_addr   <= req_addr;
                r_wdata  <= req_wdata;
            end
            if (hs && state == ST_FIRST) r_rd0 <= mem_rdata;
            if (hs && !r_write && (state == ST_SECOND || !split)) r_resp <= merged;
        end
    end

    assign resp_rdata = r_resp;

endmodule

// File: rtl/lsu_unaligned_chk.sv
module lsu_unaligned_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_be,
    input logic [31:0]       mem_wdata
);

    assert_issue_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> mem_valid);

    assert_word_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[1:0] == 2'b00 && mem_be != 4'b0000));

    assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && (mem_valid || resp_valid)));

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_be)
                                       && $stable(mem_wdata) && $stable(mem_write)));

    assert_resp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_resp_after_hs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_valid) |-> $past(mem_valid && mem_ready));

endmodule

bind lsu_unaligned lsu_unaligned_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .mem_wdata  (mem_wdata)
);

// File: tb/test_lsu_unaligned.sv
`timescale 1ns/1ps
module test_lsu_unaligned;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_big_endian = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_signed = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        resp_valid;
    logic [31:0] resp_rdata;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic        mem_write;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    lsu_unaligned i_lsu_unaligned (
        .clk(clk), .rst_n(rst_n), .cfg_big_endian(cfg_big_endian),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
        .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // Memory model with transaction log
    logic [7:0]  mem_b [0:255];
    logic [31:0] log_addr [0:7];
    logic [3:0]  log_be [0:7];
    int          log_n = 0;
    bit          stall_on = 1'b0;
    int          stall_cnt = 0;
    int          stall_seen = 0;
    int          hold_bad = 0;
    bit          hold_pend = 1'b0;
    logic [31:0] h_addr, h_wdata;
    logic [3:0]  h_be;

    assign mem_rdata = {mem_b[{mem_addr[7:2], 2'd3}], mem_b[{mem_addr[7:2], 2'd2}],
                        mem_b[{mem_addr[7:2], 2'd1}], mem_b[{mem_addr[7:2], 2'd0}]};

    always @(posedge clk) begin
        if (mem_valid && mem_ready) begin
            if (log_n < 8) begin
                log_addr[log_n] = mem_addr;
                log_be[log_n]   = mem_be;
            end
            log_n = log_n + 1;
            if (mem_write)
                for (int k = 0; k < 4; k++)
                    if (mem_be[k]) mem_b[{mem_addr[7:2], 2'(k)}] <= mem_wdata[8*k +: 8];
        end
        if (hold_pend && (mem_addr != h_addr || mem_be != h_be || mem_wdata != h_wdata))
            hold_bad = hold_bad + 1;
        hold_pend = mem_valid && !mem_ready;
        if (hold_pend) stall_seen = stall_seen + 1;
        h_addr  = mem_addr;
        h_be    = mem_be;
        h_wdata = mem_wdata;
    end

    always @(negedge clk) begin
        stall_cnt = stall_cnt + 1;
        mem_ready = !stall_on || (stall_cnt % 3 == 2);
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_req(input bit w, input logic [1:0] sz, input bit sg, input bit big,
                           input logic [31:0] a, input logic [31:0] wd,
                           output logic [31:0] rd);
        int t;
        @(negedge clk);
        chk("R9 ready before request", 32'(req_ready), 32'd1);
        log_n = 0;
        req_valid = 1'b1; req_write = w; req_size = sz; req_signed = sg;
        cfg_big_endian = big; req_addr = a; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!resp_valid && t < 1000) begin
            @(negedge clk);
            t++;
        end
        if (!resp_valid) chk("R11 response timeout", 32'd0, 32'd1);
        rd = resp_rdata;
    endtask

    function automatic logic [31:0] mem_word(input int a);
        return {mem_b[a+3], mem_b[a+2], mem_b[a+1], mem_b[a]};
    endfunction

    task automatic test_reset();
        chk("R1 ready in reset", 32'(req_ready), 32'd1);
        chk("R1 mem_valid in reset", 32'(mem_valid), 32'd0);
        chk("R1 resp_valid in reset", 32'(resp_valid), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", {req_ready, mem_valid, resp_valid}, 32'b100);
    endtask

    task automatic test_aligned_le();
        logic [31:0] rd;
        run_req(1, 2'd2, 0, 0, 32'h10, 32'h06AB434C, rd);
        chk("R2 aligned word one txn", log_n, 1);
        chk("R4 addr", log_addr[0], 32'h10);
        chk("R4 be full", 32'(log_be[0]), 32'hF);
        chk("R5 LE bytes", mem_word(16), 32'h06AB434C);
        run_req(0, 2'd2, 0, 0, 32'h10, 0, rd);
        chk("R7 LE load", rd, 32'h06AB434C);
    endtask

    task automatic test_aligned_be();
        logic [31:0] rd;
        run_req(1, 2'd3, 0, 1, 32'h20, 32'h06AB434C, rd);
        chk("R6 BE lowest byte", 32'(mem_b[8'h20]), 32'h06);
        chk("R6 BE bytes", mem_word(32), 32'h4C43AB06);
        run_req(0, 2'd2, 0, 1, 32'h20, 0, rd);
        chk("R7 BE load", rd, 32'h06AB434C);
        run_req(0, 2'd2, 0, 0, 32'h20, 0, rd);
        chk("R5 LE view of BE store", rd, 32'h4C43AB06);
    endtask

    task automatic test_split_word();
        logic [31:0] rd;
        run_req(1, 2'd2, 0, 0, 32'h31, 32'hA1B2C3D4, rd);
        chk("R3 split word two txn", log_n, 2);
        chk("R3 first addr", log_addr[0], 32'h30);
        chk("R3 first be", 32'(log_be[0]), 32'hE);
        chk("R3 second addr", log_addr[1], 32'h34);
        chk("R3 second be", 32'(log_be[1]), 32'h1);
        chk("R5 split bytes", {mem_b[8'h34], mem_b[8'h33], mem_b[8'h32], mem_b[8'h31]}, 32'hA1B2C3D4);
        chk("R4 neighbours untouched", {24'd0, mem_b[8'h30]}, 32'h0);
        run_req(0, 2'd2, 0, 0, 32'h31, 0, rd);
        chk("R7 split LE load", rd, 32'hA1B2C3D4);
        run_req(0, 2'd2, 0, 1, 32'h31, 0, rd);
        chk("R7 split BE load", rd, 32'hD4C3B2A1);
    endtask

    task automatic test_split_half();
        logic [31:0] rd;
        run_req(1, 2'd1, 0, 1, 32'h41, 32'h0000BEEF, rd);
        chk("R3 odd half two txn", log_n, 2);
        chk("R3 same word first", log_addr[0], 32'h40);
        chk("R3 same word second", log_addr[1], 32'h40);
        chk("R3 half be order", {log_be[0], log_be[1]}, 32'h24);
        chk("R6 BE half bytes", {mem_b[8'h41], mem_b[8'h42]}, 32'hBEEF);
        run_req(0, 2'd1, 1, 1, 32'h41, 0, rd);
        chk("R8 signed half", rd, 32'hFFFFBEEF);
        run_req(0, 2'd1, 0, 1, 32'h41, 0, rd);
        chk("R8 unsigned half", rd, 32'h0000BEEF);
        run_req(1, 2'd1, 0, 0, 32'h43, 32'hFFFF1234, rd);
        chk("R3 half cross addr", log_addr[1], 32'h44);
        chk("R3 half cross be", {log_be[0], log_be[1]}, 32'h81);
        chk("R5 half cross bytes", {mem_b[8'h44], mem_b[8'h43]}, 32'h1234);
        chk("R4 half cross keeps", 32'(mem_b[8'h45]), 32'h0);
    endtask

    task automatic test_byte_and_half();
        logic [31:0] rd;
        run_req(1, 2'd0, 0, 1, 32'h53, 32'h12345680, rd);
        chk("R2 byte one txn", log_n, 1);
        chk("R4 byte lane", 32'(log_be[0]), 32'h8);
        chk("R5 byte stored", 32'(mem_b[8'h53]), 32'h80);
        run_req(0, 2'd0, 1, 0, 32'h53, 0, rd);
        chk("R8 signed byte", rd, 32'hFFFFFF80);
        run_req(0, 2'd0, 0, 1, 32'h53, 0, rd);
        chk("R8 unsigned byte", rd, 32'h00000080);
        run_req(1, 2'd1, 0, 0, 32'h56, 32'h00007F01, rd);
        chk("R2 even half one txn", log_n, 1);
        chk("R4 even half be", 32'(log_be[0]), 32'hC);
        run_req(0, 2'd1, 1, 0, 32'h56, 0, rd);
        chk("R8 positive signed half", rd, 32'h00007F01);
    endtask

    task automatic test_busy();
        int t;
        int busy_bad;
        @(negedge clk);
        log_n = 0;
        req_valid = 1'b1; req_write = 1'b1; req_size = 2'd2; req_signed = 1'b0;
        cfg_big_endian = 1'b0; req_addr = 32'h61; req_wdata = 32'h11223344;
        @(posedge clk);
        @(negedge clk);
        req_size = 2'd0; req_addr = 32'h70; req_wdata = 32'h000000EE;
        t = 0;
        busy_bad = 0;
        while (!resp_valid && t < 1000) begin
            if (req_ready) busy_bad++;
            @(negedge clk);
            t++;
        end
        chk("R9 ready low while busy", busy_bad, 0);
        chk("R9 no extra txn", log_n, 2);
        chk("R11 response seen", 32'(resp_valid), 32'd1);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R11 single pulse", 32'(resp_valid), 32'd0);
        chk("R9 held request not issued", 32'(mem_b[8'h70]), 32'h0);
        chk("R5 busy store bytes", {mem_b[8'h64], mem_b[8'h63], mem_b[8'h62], mem_b[8'h61]}, 32'h11223344);
    endtask

    task automatic test_stall();
        logic [31:0] rd;
        stall_on = 1'b1;
        run_req(0, 2'd2, 0, 0, 32'h31, 0, rd);
        stall_on = 1'b0;
        chk("R10 stalls occurred", 32'(stall_seen > 0), 32'd1);
        chk("R10 fields held", hold_bad, 0);
        chk("R10 txn count under stall", log_n, 2);
        chk("R7 load under stall", rd, 32'hA1B2C3D4);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem_b[i] = 8'h00;
        repeat (3) @(negedge clk);
        test_reset();
        test_aligned_le();
        test_aligned_be();
        test_split_word();
        test_split_half();
        test_byte_and_half();
        test_busy();
        test_stall();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule